// File: doc/BRIEF.md
# Single-Clock Look-Ahead FIFO for One AXI Channel

This block sits on one AXI channel and decouples its producer from its consumer. The producer offers a word on the upstream valid/ready port. The consumer takes words from the downstream valid/ready port. Every information signal of the channel (ID, data, response code, last marker) is packed into one stored word and unpacked again on the output side. Both sides share one clock.

The output is always look-ahead. The oldest stored word sits on the downstream fields with no request beforehand, and each downstream handshake moves to the next word. Upstream ready comes only from free space, and downstream valid comes only from stored data. Two threshold flags and two occupancy counts give early warning that the FIFO is nearly empty or nearly full. The thresholds are fixed by parameters.

Top module: `axi_chan_fifo`

## Requirements
- R1: A word is taken in only in a cycle where `up_valid` and `up_ready` are both high, and a word is given out only in a cycle where `dn_valid` and `dn_ready` are both high.
- R2: Once reset has been released and one clock edge has passed, `up_ready` is high exactly when fewer than DEPTH words are stored.
- R3: `dn_valid` is high exactly when at least one word is stored.
- R4: The downstream fields always show the oldest stored word, with no request beforehand. Each downstream handshake advances to the next word in arrival order.
- R5: The stored word packs ID, data, response and last. Every field comes out bit for bit as it went in.
- R6: `almost_empty` is high exactly when the stored count is at or below LO_MARK.
- R7: `almost_full` is high exactly when the stored count is at or above HI_MARK.
- R8: `fill_wr` and `fill_rd` both equal the number of stored words. They are $clog2(DEPTH)+1 bits wide, so they reach DEPTH when the FIFO is full. A cycle with both an upstream and a downstream handshake leaves them unchanged.
- R9: While `rst_n` is low (asynchronous, active low), the count is 0, `up_ready` and `dn_valid` are low, `almost_empty` is high and `almost_full` is low.
- R10: An upstream word offered while the FIFO is full is not stored. After a full FIFO is drained, exactly the DEPTH words taken before it filled come out, and then `dn_valid` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Asynchronous reset, active low |
| up_valid | input | 1 | Upstream word offered |
| up_ready | output | 1 | Free slot available |
| up_id | input | ID_W | Upstream ID field |
| up_data | input | DATA_W | Upstream data field |
| up_resp | input | RESP_W | Upstream response field |
| up_last | input | 1 | Upstream last marker |
| dn_valid | output | 1 | Oldest word present |
| dn_ready | input | 1 | Consumer takes the word |
| dn_id | output | ID_W | Downstream ID field |
| dn_data | output | DATA_W | Downstream data field |
| dn_resp | output | RESP_W | Downstream response field |
| dn_last | output | 1 | Downstream last marker |
| fill_wr | output | $clog2(DEPTH)+1 | Stored word count, write view |
| fill_rd | output | $clog2(DEPTH)+1 | Stored word count, read view |
| almost_empty | output | 1 | Count at or below LO_MARK |
| almost_full | output | 1 | Count at or above HI_MARK |

## Verification
A store and a removal can land in the same cycle. The count must then hold still while both pointers move. The bench provokes this with random valid and ready streams at several duty mixes. It also makes it happen at the edges: one stored word with both sides active, and a full FIFO where only the removal can happen because ready is low. Each case is judged against a queue model kept in the bench, which compares the counts, flags, handshake outputs and the word at the head of the queue every cycle.

// File: rtl/acf_pkg.sv
package acf_pkg;

    // Kind of pointer movement in one cycle
    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_PUSH = 2'b01,
        OP_POP  = 2'b10,
        OP_BOTH = 2'b11
    } fifo_op_e;

    function automatic fifo_op_e make_op(input logic push, input logic pop);
        return fifo_op_e'({pop, push});
    endfunction

endpackage

// File: rtl/acf_store.sv
module acf_store #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_word,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_word
);

    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_addr] <= wr_word;
    end

    // Combinational read: the head word falls through with no request
    assign rd_word = mem_q[rd_addr];

endmodule

// File: rtl/acf_ctrl.sv
module acf_ctrl
    import acf_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int LO_MARK = 5,
    parameter int HI_MARK = 11,
    localparam int AW     = $clog2(DEPTH),
    localparam int CW     = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          up_valid,
    input  logic          dn_ready,
    output logic          up_ready,
    output logic          dn_valid,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic [CW-1:0] fill,
    output logic          almost_empty,
    output logic          almost_full
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [CW-1:0] LO_CNT   = CW'(LO_MARK);
    localparam logic [CW-1:0] HI_CNT   = CW'(HI_MARK);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] cnt;
        logic          rdy;
        logic          vld;
        logic          lo;
        logic          hi;
    } ctrl_s;

    ctrl_s    st_q, st_d;
    logic     push, pop;
    fifo_op_e op;

    // R1: movement only on a full handshake
    assign push = up_valid & st_q.rdy;
    assign pop  = st_q.vld & dn_ready;
    assign op   = make_op(push, pop);

    always_comb begin
        st_d = st_q;
        unique case (op)
            OP_PUSH: begin
                st_d.wptr = st_q.wptr + AW'(1);
                st_d.cnt  = st_q.cnt + CW'(1);
            end
            OP_POP: begin
                st_d.rptr = st_q.rptr + AW'(1);
                st_d.cnt  = st_q.cnt - CW'(1);
            end
            OP_BOTH: begin
                st_d.wptr = st_q.wptr + AW'(1);
                st_d.rptr = st_q.rptr + AW'(1);
            end
            default: ;
        endcase
        st_d.rdy = (st_d.cnt != FULL_CNT);
        st_d.vld = (st_d.cnt != '0);
        st_d.lo  = (st_d.cnt <= LO_CNT);
        st_d.hi  = (st_d.cnt >= HI_CNT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{wptr: '0, rptr: '0, cnt: '0, rdy: 1'b0,
                      vld: 1'b0, lo: 1'b1, hi: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign up_ready     = st_q.rdy;
    assign dn_valid     = st_q.vld;
    assign wr_en        = push;
    assign wr_addr      = st_q.wptr;
    assign rd_addr      = st_q.rptr;
    assign fill         = st_q.cnt;
    assign almost_empty = st_q.lo;
    assign almost_full  = st_q.hi;

    // R2 / R10: no acceptance while every slot is taken
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == FULL_CNT) |-> !up_ready);
    // R2: ready returns once space is available
    p_ready_space_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt != FULL_CNT) |=> $past(st_q.cnt != FULL_CNT) && (push || up_ready || st_q.cnt == FULL_CNT));
    // R3: valid tracks stored data
    p_valid_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid == (st_q.cnt != '0));
    // R8: simultaneous push and pop keep the count
    p_count_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop) |=> $stable(fill));
    // R6: empty-side flag inclusive
    p_lo_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        almost_empty == (fill <= LO_CNT));
    // R7: full-side flag inclusive
    p_hi_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        almost_full == (fill >= HI_CNT));

endmodule

// File: rtl/axi_chan_fifo.sv
module axi_chan_fifo #(
    parameter int DEPTH   = 16,
    parameter int ID_W    = 4,
    parameter int DATA_W  = 32,
    parameter int RESP_W  = 2,
    parameter int LO_MARK = 5,
    parameter int HI_MARK = 11,
    localparam int AW     = $clog2(DEPTH),
    localparam int CW     = AW + 1,
    localparam int W      = ID_W + DATA_W + RESP_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic [ID_W-1:0]   up_id,
    input  logic [DATA_W-1:0] up_data,
    input  logic [RESP_W-1:0] up_resp,
    input  logic              up_last,
    output logic              dn_valid,
    input  logic              dn_ready,
    output logic [ID_W-1:0]   dn_id,
    output logic [DATA_W-1:0] dn_data,
    output logic [RESP_W-1:0] dn_resp,
    output logic              dn_last,
    output logic [CW-1:0]     fill_wr,
    output logic [CW-1:0]     fill_rd,
    output logic              almost_empty,
    output logic              almost_full
);

    logic          wr_en;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [W-1:0]  wr_word, rd_word;
    logic [CW-1:0] fill;

    // R5: pack every information field into one word
    assign wr_word = {up_id, up_data, up_resp, up_last};
    assign {dn_id, dn_data, dn_resp, dn_last} = rd_word;

    acf_ctrl #(
        .DEPTH  (DEPTH),
        .LO_MARK(LO_MARK),
        .HI_MARK(HI_MARK)
    ) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .up_valid    (up_valid),
        .dn_ready    (dn_ready),
        .up_ready    (up_ready),
        .dn_valid    (dn_valid),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .rd_addr     (rd_addr),
        .fill        (fill),
        .almost_empty(almost_empty),
        .almost_full (almost_full)
    );

    acf_store #(
        .W    (W),
        .DEPTH(DEPTH)
    ) store_i (
        .clk    (clk),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_word(wr_word),
        .rd_addr(rd_addr),
        .rd_word(rd_word)
    );

    // Single clock: both count views are the same register
    assign fill_wr = fill;
    assign fill_rd = fill;

endmodule

// File: tb/axi_chan_fifo_tb_top.sv
module axi_chan_fifo_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH   = 16;
    localparam int ID_W    = 4;
    localparam int DATA_W  = 32;
    localparam int RESP_W  = 2;
    localparam int LO_MARK = 5;
    localparam int HI_MARK = 11;
    localparam int CW      = $clog2(DEPTH) + 1;
    localparam int W       = ID_W + DATA_W + RESP_W + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic up_valid = 1'b0, dn_ready = 1'b0;
    logic up_ready, dn_valid, up_last = 1'b0, dn_last;
    logic [ID_W-1:0]   up_id = '0, dn_id;
    logic [DATA_W-1:0] up_data = '0, dn_data;
    logic [RESP_W-1:0] up_resp = '0, dn_resp;
    logic [CW-1:0]     fill_wr, fill_rd;
    logic almost_empty, almost_full;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [W-1:0] model_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    axi_chan_fifo #(
        .DEPTH(DEPTH), .ID_W(ID_W), .DATA_W(DATA_W), .RESP_W(RESP_W),
        .LO_MARK(LO_MARK), .HI_MARK(HI_MARK)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .up_valid(up_valid), .up_ready(up_ready),
        .up_id(up_id), .up_data(up_data), .up_resp(up_resp), .up_last(up_last),
        .dn_valid(dn_valid), .dn_ready(dn_ready),
        .dn_id(dn_id), .dn_data(dn_data), .dn_resp(dn_resp), .dn_last(dn_last),
        .fill_wr(fill_wr), .fill_rd(fill_rd),
        .almost_empty(almost_empty), .almost_full(almost_full)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit exp_lo(input int n);
        return n <= LO_MARK;
    endfunction

    function automatic bit exp_hi(input int n);
        return n >= HI_MARK;
    endfunction

    function automatic logic [W-1:0] rand_word();
        return {ID_W'($urandom), DATA_W'($urandom), RESP_W'($urandom), 1'($urandom)};
    endfunction

    // One cycle: check outputs at the falling edge, drive inputs, update model
    task automatic step(input bit sv, input bit mr);
        logic [W-1:0] w, head;
        int n;
        @(negedge clk);
        n = model_q.size();
        chk(up_ready == (n != DEPTH), "R2 up_ready", 64'(up_ready), 64'(n != DEPTH));
        chk(dn_valid == (n != 0), "R3 dn_valid", 64'(dn_valid), 64'(n != 0));
        chk(int'(fill_wr) == n, "R1 R8 fill_wr", 64'(fill_wr), 64'(n));
        chk(int'(fill_rd) == n, "R8 fill_rd", 64'(fill_rd), 64'(n));
        chk(almost_empty == exp_lo(n), "R6 almost_empty", 64'(almost_empty), 64'(exp_lo(n)));
        chk(almost_full == exp_hi(n), "R7 almost_full", 64'(almost_full), 64'(exp_hi(n)));
        if (n != 0) begin
            head = model_q[0];
            chk({dn_id, dn_data, dn_resp, dn_last} == head, "R4 R5 head word",
                64'({dn_id, dn_data, dn_resp, dn_last}), 64'(head));
        end
        w = rand_word();
        {up_id, up_data, up_resp, up_last} = w;
        up_valid = sv;
        dn_ready = mr;
        // R1: model moves only on handshakes seen at the ports
        if (dn_valid && mr) void'(model_q.pop_front());
        if (sv && up_ready) model_q.push_back(w);
    endtask

    initial begin
        void'($urandom(32'd1234));
        // R9: reset state while rst_n is low
        repeat (3) @(negedge clk);
        chk(fill_wr == '0, "R9 fill", 64'(fill_wr), 64'd0);
        chk(up_ready == 1'b0, "R9 up_ready", 64'(up_ready), 64'd0);
        chk(dn_valid == 1'b0, "R9 dn_valid", 64'(dn_valid), 64'd0);
        chk(almost_empty == 1'b1, "R9 almost_empty", 64'(almost_empty), 64'd1);
        chk(almost_full == 1'b0, "R9 almost_full", 64'(almost_full), 64'd0);
        rst_n = 1'b1;
        @(posedge clk);

        // R10: fill past capacity while offering words
        for (int i = 0; i < DEPTH + 4; i++) step(1'b1, 1'b0);
        @(negedge clk);
        chk(fill_wr == CW'(DEPTH), "R10 full count", 64'(fill_wr), 64'(DEPTH));
        chk(up_ready == 1'b0, "R10 ready low at full", 64'(up_ready), 64'd0);
        // R8: at full only the pop side moves; then drain completely
        for (int i = 0; i < DEPTH + 3; i++) step(1'b0, 1'b1);
        @(negedge clk);
        chk(dn_valid == 1'b0, "R10 drained", 64'(dn_valid), 64'd0);
        chk(model_q.size() == 0, "R10 model empty", 64'(model_q.size()), 64'd0);

        // R8: single stored word with push and pop together
        step(1'b1, 1'b0);
        for (int i = 0; i < 6; i++) step(1'b1, 1'b1);

        // Random phases with several duty mixes
        for (int ph = 0; ph < 4; ph++) begin
            int wp, rp;
            case (ph)
                0: begin wp = 75; rp = 30; end
                1: begin wp = 30; rp = 75; end
                2: begin wp = 50; rp = 50; end
                default: begin wp = 95; rp = 90; end
            endcase
            for (int i = 0; i < 800; i++)
                step(($urandom % 100) < wp, ($urandom % 100) < rp);
        end
        step(1'b0, 1'b0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule